// File: doc/BRIEF.md
# Threshold-Flushed Dual-Clock Byte Buffer

This block is a byte-wide first-in first-out store. Its write side and its read side run on two unrelated clocks. A fast sample producer pushes bytes on the write clock, and the buffer takes them with no backpressure. The consumer on the read side is a slow host link that does not poll byte by byte. When the fill level seen on the read side comes within a small margin of capacity, the buffer raises a transfer request. It then streams its whole contents out, one byte per read-clock cycle. It marks the end with a one-cycle completion pulse, and the host is free until the next request.

The two pointers cross between domains as Gray code through two-stage synchronisers. Each side computes its fill level from its own pointer and the synchronised copy of the other. The write side sees a fill level that is never lower than the true one. A write that arrives when that level equals capacity is dropped and sets a sticky overflow flag. Bytes written while a flush is running are accepted. They join the current burst if they become visible on the read side before the buffer reads empty. Otherwise they wait for the next burst. Capacity is set by `ADDR_W`: production instances use `ADDR_W=13` (8192 bytes), and the default is a 1024-byte configuration.

Top module: `xfer_fifo`

## Requirements
- R1: After reset, `xfer_req`, `rd_valid`, `flush_done` and `overflow` are all 0.
- R2: Bytes leave on `rd_data` in exactly the order they were accepted on `wr_data`.
- R3: `xfer_req` stays 0 while the buffer holds fewer than 2**ADDR_W − MARGIN bytes (MARGIN defaults to 3). It rises once the synchronised fill level reaches that value. The first byte is presented in the read cycle after the rise.
- R4: A burst delivers every byte that is visible on the read side. When the writer is idle, the number of bytes delivered equals the number written.
- R5: Within a burst, `rd_valid` is 1 in every read cycle from the first byte to the last, with no gaps.
- R6: `flush_done` is a single-cycle pulse in the read cycle right after the last byte. In that cycle `xfer_req` and `rd_valid` are 0.
- R7: A write attempted while the write side sees 2**ADDR_W bytes stored is discarded, and the byte never appears on the output. `overflow` becomes 1 and stays 1 until reset. Without such a write, `overflow` stays 0.
- R8: Writes are accepted during a burst and are all delivered in order, in this burst or a later one.
- R9: `rd_valid` is 1 only while `xfer_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| wrst_n | input | 1 | Write-domain reset, active low, asynchronous |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | DATA_W | Byte to store |
| overflow | output | 1 | Sticky flag: a write was discarded because the buffer was full |
| rclk | input | 1 | Read-domain clock |
| rrst_n | input | 1 | Read-domain reset, active low, asynchronous |
| xfer_req | output | 1 | Transfer request, held high for the whole burst |
| rd_valid | output | 1 | `rd_data` carries a byte this cycle |
| rd_data | output | DATA_W | Outgoing byte |
| flush_done | output | 1 | One-cycle pulse after the last byte of a burst |

## Verification
Assertions check the following on every cycle: the burst framing and the ordering of strobes. A burst starts the cycle after the request rises, has no gaps in `rd_valid`, carries no valid byte outside a request, and ends with a lone completion pulse. They also check that the overflow flag stays set. Byte order, byte count and the threshold point depend on what was written. Only the bench scenarios can show these: a directed fill to just below and then at the threshold, a stretch of random write traffic that spans several bursts, and a back-to-back overfill whose discarded bytes must be missing from the output.

// File: rtl/xfer_fifo.sv
module xfer_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10,
  parameter int MARGIN = 3
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              overflow,
  input  logic              rclk,
  input  logic              rrst_n,
  output logic              xfer_req,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              flush_done
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PW-1:0] CAP  = PW'(DEPTH);
  localparam logic [PW-1:0] TRIG = PW'(DEPTH - MARGIN);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];

  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2;
  logic [PW-1:0] rbin, rgray, wg_s1, wg_s2;
  logic          flushing;

  wire [PW-1:0] wbin_nxt = wbin + 1'b1;
  wire [PW-1:0] wfill    = wbin - g2b(rg_s2);
  wire          wfull    = (wfill == CAP);
  wire          wpush    = wr_en && !wfull;

  always_ff @(posedge wclk or negedge wrst_n)
    if (!wrst_n) begin
      wbin     <= '0;
      wgray    <= '0;
      rg_s1    <= '0;
      rg_s2    <= '0;
      overflow <= 1'b0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wpush) begin
        wbin  <= wbin_nxt;
        wgray <= wbin_nxt ^ (wbin_nxt >> 1);
      end
      if (wr_en && wfull) overflow <= 1'b1;
    end

  always_ff @(posedge wclk)
    if (wpush) mem[wbin[ADDR_W-1:0]] <= wr_data;

  wire [PW-1:0] rbin_nxt = rbin + 1'b1;
  wire [PW-1:0] rfill    = g2b(wg_s2) - rbin;
  wire          rempty   = (rfill == '0);
  wire          rpop     = flushing && !rempty;

  always_ff @(posedge rclk or negedge rrst_n)
    if (!rrst_n) begin
      rbin       <= '0;
      rgray      <= '0;
      wg_s1      <= '0;
      wg_s2      <= '0;
      flushing   <= 1'b0;
      rd_valid   <= 1'b0;
      flush_done <= 1'b0;
    end else begin
      wg_s1      <= wgray;
      wg_s2      <= wg_s1;
      rd_valid   <= rpop;
      flush_done <= flushing && rempty;
      if (!flushing)   flushing <= (rfill >= TRIG);
      else if (rempty) flushing <= 1'b0;
      if (rpop) begin
        rbin  <= rbin_nxt;
        rgray <= rbin_nxt ^ (rbin_nxt >> 1);
      end
    end

  always_ff @(posedge rclk)
    if (rpop) rd_data <= mem[rbin[ADDR_W-1:0]];

  assign xfer_req = flushing;
endmodule

// File: rtl/xfer_fifo_chk.sv
module xfer_fifo_chk (
  input logic wclk,
  input logic wrst_n,
  input logic rclk,
  input logic rrst_n,
  input logic overflow,
  input logic xfer_req,
  input logic rd_valid,
  input logic flush_done
);
  // R3
  burst_start_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    $rose(xfer_req) |=> rd_valid);

  // R5
  no_gap_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_valid |=> (rd_valid || flush_done));

  // R6
  done_pulse_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    flush_done |=> !flush_done);

  // R6
  done_quiet_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    flush_done |-> (!xfer_req && !rd_valid));

  // R9
  valid_in_req_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_valid |-> xfer_req);

  // R7
  sticky_ovf_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    overflow |=> overflow);
endmodule

bind xfer_fifo xfer_fifo_chk u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
  .overflow(overflow), .xfer_req(xfer_req),
  .rd_valid(rd_valid), .flush_done(flush_done)
);

// File: tb/xfer_fifo_test.sv
`timescale 1ns/1ps
module xfer_fifo_test;
  localparam int DW = 8, AW = 10, MG = 3;
  localparam int DEPTH = 1 << AW, TRIG = DEPTH - MG;

  logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0, wr_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic overflow, xfer_req, rd_valid, flush_done;
  logic [DW-1:0] rd_data;

  always #2 wclk = ~wclk;
  always #5.15 rclk = ~rclk;

  xfer_fifo #(.DATA_W(DW), .ADDR_W(AW), .MARGIN(MG)) uut (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data),
    .overflow(overflow), .rclk(rclk), .rrst_n(rrst_n), .xfer_req(xfer_req),
    .rd_valid(rd_valid), .rd_data(rd_data), .flush_done(flush_done));

  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] exp_q[$], got_q[$];
  int done_cnt = 0, gap_bad = 0, done_bad = 0, req_seen = 0;
  logic prev_valid = 0, prev_done = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge rclk) if (rrst_n) begin
    if (rd_valid) got_q.push_back(rd_data);
    if (xfer_req) req_seen++;
    if (prev_valid && !rd_valid && !flush_done) gap_bad++;
    if (flush_done) begin
      done_cnt++;
      if (xfer_req || rd_valid || !prev_valid || prev_done) done_bad++;
    end
    prev_valid = rd_valid;
    prev_done  = flush_done;
  end

  task automatic put(input logic [DW-1:0] d);
    @(negedge wclk); wr_en = 1; wr_data = d;
  endtask
  task automatic idle(input int n);
    @(negedge wclk); wr_en = 0;
    repeat (n) @(negedge wclk);
  endtask
  task automatic rwait(input int n);
    repeat (n) @(negedge rclk);
  endtask
  task automatic wait_done(input int n);
    while (done_cnt < n) @(negedge rclk);
  endtask

  task automatic compare_all(input string req);
    check(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], "R2", got_q[i], exp_q[i]);
  endtask

  initial begin : wd
    repeat (150000) @(posedge wclk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    int r, rem, d0;
    r = $urandom(32'd2024);
    #1;
    check(xfer_req == 0 && rd_valid == 0 && flush_done == 0 && overflow == 0, "R1", xfer_req, 0);
    repeat (3) @(negedge wclk);
    wrst_n = 1; rrst_n = 1;
    rwait(2);
    // R1: reset state
    check(xfer_req == 0, "R1", xfer_req, 0);
    check(rd_valid == 0, "R1", rd_valid, 0);
    check(flush_done == 0, "R1", flush_done, 0);
    check(overflow == 0, "R1", overflow, 0);

    // R3: one below threshold then at threshold
    for (int i = 0; i < TRIG - 1; i++) begin
      put(DW'(i * 7 + 3)); exp_q.push_back(DW'(i * 7 + 3));
    end
    idle(1);
    rwait(40);
    check(req_seen == 0, "R3", req_seen, 0);
    check(got_q.size() == 0, "R3", got_q.size(), 0);
    put(8'hA5); exp_q.push_back(8'hA5);
    idle(1);
    rwait(8);
    check(req_seen > 0, "R3", req_seen, 1);
    wait_done(1);
    rwait(4);
    // R4, R2: whole contents, in order
    compare_all("R4");
    check(gap_bad == 0, "R5", gap_bad, 0);
    check(done_bad == 0, "R6", done_bad, 0);

    // R8: random sparse traffic across several bursts
    d0 = done_cnt;
    for (int i = 0; i < 3 * DEPTH; i++) begin
      logic [DW-1:0] b;
      b = DW'($urandom);
      put(b); exp_q.push_back(b);
      idle(6 + $urandom % 9);
    end
    rwait(60);
    rem = exp_q.size() - got_q.size();
    check(xfer_req == 0, "R8", xfer_req, 0);
    check(rem >= 0 && rem < TRIG, "R8", rem, 0);
    for (int i = 0; i < TRIG - rem; i++) begin
      put(DW'(i ^ 8'h5C)); exp_q.push_back(DW'(i ^ 8'h5C));
    end
    idle(1);
    wait_done(done_cnt + 1);
    rwait(60);
    check(done_cnt - d0 >= 3, "R8", done_cnt - d0, 3);
    compare_all("R8");
    check(overflow == 0, "R7", overflow, 0);
    check(gap_bad == 0, "R5", gap_bad, 0);
    check(done_bad == 0, "R6", done_bad, 0);

    // R7: back-to-back overfill
    begin
      logic [DW-1:0] ov[$];
      int base, j;
      base = got_q.size();
      for (int i = 0; i < DEPTH + 6; i++) begin
        put(DW'(i + 11)); ov.push_back(DW'(i + 11));
      end
      idle(1);
      wait_done(done_cnt + 1);
      rwait(60);
      check(overflow == 1, "R7", overflow, 1);
      check(got_q.size() - base >= DEPTH, "R7", got_q.size() - base, DEPTH);
      for (int i = 0; i < DEPTH && base + i < got_q.size(); i++)
        check(got_q[base + i] == ov[i], "R7", got_q[base + i], ov[i]);
      // remaining output must be an in-order subsequence of the tail
      j = DEPTH;
      for (int i = base + DEPTH; i < got_q.size(); i++) begin
        while (j < ov.size() && ov[j] != got_q[i]) j++;
        check(j < ov.size(), "R7", got_q[i], -1);
        j++;
      end
      check(got_q.size() - base < DEPTH + 6, "R7", got_q.size() - base, DEPTH + 5);
      idle(50);
      check(overflow == 1, "R7", overflow, 1);
    end
    check(gap_bad == 0, "R5", gap_bad, 0);
    check(done_bad == 0, "R6", done_bad, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule